// File: doc/BRIEF.md
# Sixteen-Slice Interleaved Result Multiplexer

This block sits behind a bank of sixteen parallel conversion slices that take turns sampling one analog input, one slice per clock cycle. Each slice hands over its 11-bit result (a 10-bit straight-binary code and an overrange flag) with a one-cycle transfer strobe. The block keeps each slice's latest result, picks the slices in sampling order, and drives a single registered output bus. Each word appears a fixed 12 cycles after its sample was taken.

Cycles are counted from the first rising edge at which reset is low; that cycle is numbered 0. Sample n belongs to slice n mod 16. Its word is registered at the end of cycle n+11, so it is visible on the ports during cycle n+12. A slice may hand its result over in any cycle from n-4 to n+11. A transfer in cycle n+11 is passed straight through to the output register.

When a result carries the overrange flag, the data field is forced to all ones. An active-high disable input floats the eleven data and overrange lines. The data-valid strobe stays driven, and the internal pipeline keeps running whatever the state of the disable input.

Top module: `slice_interleave_mux`

## Requirements
- R1: While reset is applied, and in cycle 0 after it, out_vld_o is 0 and the registered code and overrange bit are 0.
- R2: Sample n is owned by slice n mod 16. Its word is presented in cycle n+12 with out_vld_o high for that one cycle.
- R3: out_vld_o stays 0 in cycles 0 through 11 after reset, even when every slice strobes in every cycle.
- R4: A transfer for sample n is accepted in any cycle from n-4 to n+11. A transfer in cycle n+11 is forwarded in the same cycle without first being stored.
- R5: If a slice transfers more than once inside the window of sample n, the last transfer is the one presented.
- R6: If a slice made no transfer since its previous word was presented, out_vld_o is 0 in that output cycle and the code and overrange outputs hold their previous values.
- R7: Result bit 10 is the overrange flag. When it is 1, out_ovr_o is 1 and out_code_o is 10'h3FF, whatever result bits 9:0 held.
- R8: When result bit 10 is 0, out_code_o equals result bits 9:0 unchanged, with bit 0 as the least significant bit. This includes the extreme codes 0 and 10'h3FF.
- R9: While out_dis_i is 1, out_code_o and out_ovr_o are high-impedance and out_vld_o still follows R2 and R6.
- R10: out_dis_i never stalls or changes the internal pipeline: words presented after it drops are the same as with no disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| out_dis_i | input | 1 | 1 floats out_code_o and out_ovr_o |
| xfer_i | input | 16 | Per-slice transfer strobe, bit k for slice k |
| res_i | input | 16x11 | Per-slice result; element k bit 10 is overrange, bits 9:0 the code |
| out_code_o | output | 10 | Registered straight-binary code, tri-stated |
| out_ovr_o | output | 1 | Registered overrange flag, tri-stated |
| out_vld_o | output | 1 | One-cycle strobe marking a freshly presented word |

## Verification
If the slot pointer starts at the wrong value, the first valid word in cycle 12 comes from the wrong slice, and the fault shows within one check. If a holding flag is not cleared when its word is read, the next missed transfer on that slice produces an extra valid word 16 cycles later instead of a gap. A slip in the fill counter moves the first valid strobe away from cycle 12. A saturation or disable fault appears on the very word that carries the overrange flag or falls inside the disable window.

// File: rtl/ilvmux_pkg.sv
package ilvmux_pkg;

    localparam int unsigned SLICES_DEF = 16;
    localparam int unsigned LAT_DEF    = 12;
    localparam int unsigned CODE_W     = 10;

    // One slice result: overrange flag above the straight-binary code
    typedef struct packed {
        logic              ovr;
        logic [CODE_W-1:0] code;
    } res_t;

    localparam int unsigned RES_W = $bits(res_t);

    // Where the word read in the current cycle comes from
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HELD = 2'd1,
        SRC_LIVE = 2'd2
    } src_e;

    // Overrange forces the data field to full scale
    function automatic res_t clamp_word(input res_t r);
        res_t o;
        o = r;
        if (r.ovr) begin
            o.code = '1;
        end
        return o;
    endfunction

    // Slot read in cycle 0 so that slot 0 is read in cycle lat-1
    function automatic int unsigned first_slot(input int unsigned n, input int unsigned lat);
        return (n - ((lat - 1) % n)) % n;
    endfunction

endpackage

// File: rtl/ilvmux_seq.sv
module ilvmux_seq
    import ilvmux_pkg::*;
#(
    parameter int unsigned NUM_SLICES = SLICES_DEF,
    parameter int unsigned LATENCY    = LAT_DEF,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLICES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic              rd_armed_o
);

    localparam int unsigned FILL_W = $clog2(LATENCY) + 1;
    localparam int unsigned START  = first_slot(NUM_SLICES, LATENCY);
    localparam logic [FILL_W-1:0] ARM_AT    = FILL_W'(LATENCY - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLICES - 1);

    logic [FILL_W-1:0] fill_q;
    logic [SLOT_W-1:0] slot_q;

    // Counts cycles since reset until the first read is due
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (fill_q != ARM_AT) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    // Round-robin read pointer, one slot per cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_W'(START);
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign rd_slot_o  = slot_q;
    assign rd_armed_o = (fill_q == ARM_AT);

endmodule

// File: rtl/ilvmux_bank.sv
module ilvmux_bank
    import ilvmux_pkg::*;
#(
    parameter int unsigned NUM_SLICES = SLICES_DEF,
    localparam int unsigned SLOT_W    = $clog2(NUM_SLICES)
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_SLICES-1:0]                 xfer_i,
    input  logic [NUM_SLICES-1:0][RES_W-1:0]      res_i,
    input  logic [SLOT_W-1:0]                     rd_slot_i,
    input  logic                                  rd_armed_i,
    output res_t                                  sel_word_o,
    output src_e                                  sel_src_o
);

    res_t                  held_arr [NUM_SLICES];
    logic [NUM_SLICES-1:0] full_vec;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slot
        res_t held_q;
        logic full_q;
        logic take;

        assign take = rd_armed_i && (rd_slot_i == SLOT_W'(s));

        // A read empties the slot; a strobe while not being read fills it.
        // A strobe in the read cycle bypasses the slot entirely.
        always_ff @(posedge clk) begin
            if (rst) begin
                held_q <= '0;
                full_q <= 1'b0;
            end else if (take) begin
                full_q <= 1'b0;
            end else if (xfer_i[s]) begin
                held_q <= res_t'(res_i[s]);
                full_q <= 1'b1;
            end
        end

        assign held_arr[s] = held_q;
        assign full_vec[s] = full_q;
    end

    always_comb begin
        sel_src_o  = SRC_NONE;
        sel_word_o = held_arr[rd_slot_i];
        if (rd_armed_i) begin
            if (xfer_i[rd_slot_i]) begin
                sel_src_o  = SRC_LIVE;
                sel_word_o = res_t'(res_i[rd_slot_i]);
            end else if (full_vec[rd_slot_i]) begin
                sel_src_o  = SRC_HELD;
            end
        end
    end

endmodule

// File: rtl/ilvmux_out.sv
module ilvmux_out
    import ilvmux_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e src_i,
    input  res_t word_i,
    output res_t word_q_o,
    output logic vld_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= (src_i != SRC_NONE);
            if (src_i != SRC_NONE) begin
                word_q_o <= clamp_word(word_i);
            end
        end
    end

endmodule

// File: rtl/slice_interleave_mux.sv
module slice_interleave_mux
    import ilvmux_pkg::*;
#(
    parameter int unsigned NUM_SLICES = SLICES_DEF,
    parameter int unsigned LATENCY    = LAT_DEF
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             out_dis_i,
    input  logic [NUM_SLICES-1:0]            xfer_i,
    input  logic [NUM_SLICES-1:0][RES_W-1:0] res_i,
    output wire  [CODE_W-1:0]                out_code_o,
    output wire                              out_ovr_o,
    output logic                             out_vld_o
);

    localparam int unsigned SLOT_W = $clog2(NUM_SLICES);

    logic [SLOT_W-1:0] rd_slot;
    logic              rd_armed;
    res_t              sel_word;
    src_e              sel_src;
    res_t              word_q;

    ilvmux_seq #(
        .NUM_SLICES (NUM_SLICES),
        .LATENCY    (LATENCY)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rd_slot_o  (rd_slot),
        .rd_armed_o (rd_armed)
    );

    ilvmux_bank #(
        .NUM_SLICES (NUM_SLICES)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .xfer_i     (xfer_i),
        .res_i      (res_i),
        .rd_slot_i  (rd_slot),
        .rd_armed_i (rd_armed),
        .sel_word_o (sel_word),
        .sel_src_o  (sel_src)
    );

    ilvmux_out u_out (
        .clk      (clk),
        .rst      (rst),
        .src_i    (sel_src),
        .word_i   (sel_word),
        .word_q_o (word_q),
        .vld_o    (out_vld_o)
    );

    // Drivers float after the register; the pipeline never sees the disable
    assign out_code_o = out_dis_i ? {CODE_W{1'bz}} : word_q.code;
    assign out_ovr_o  = out_dis_i ? 1'bz : word_q.ovr;

endmodule

// File: rtl/ilvmux_chk.sv
module ilvmux_chk #(
    parameter int unsigned LATENCY = 12,
    parameter int unsigned CODE_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              vld,
    input logic [CODE_W-1:0] q_code,
    input logic              q_ovr
);

    localparam int unsigned CNT_W = $clog2(LATENCY + 1);

    logic [CNT_W-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '0;
        end else if (since_q != CNT_W'(LATENCY)) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!vld && (q_code == '0) && !q_ovr));

    // R3
    fill_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (since_q < CNT_W'(LATENCY)) |-> !vld);

    // R6
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |-> ($stable(q_code) && $stable(q_ovr)));

    // R7
    ovr_saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && q_ovr) |-> (&q_code));

endmodule

bind slice_interleave_mux ilvmux_chk #(
    .LATENCY (LATENCY),
    .CODE_W  (ilvmux_pkg::CODE_W)
) u_ilvmux_chk (
    .clk    (clk),
    .rst    (rst),
    .vld    (out_vld_o),
    .q_code (word_q.code),
    .q_ovr  (word_q.ovr)
);

// File: tb/test_slice_interleave_mux.sv
module test_slice_interleave_mux;

    localparam int NS   = 16;
    localparam int LAT  = 12;
    localparam int NTAB = 24;
    localparam int NSMP = 48;
    localparam int NCYC = 80;

    typedef struct packed {
        logic               skip;
        logic               decoy;
        logic signed [4:0]  off;
        logic [10:0]        res;
    } vec_t;

    // Per-sample stimulus: skip, decoy at n-4, transfer offset, result
    localparam vec_t VEC [NTAB] = '{
        '{1'b0, 1'b0,  5'sd11, 11'h000},
        '{1'b0, 1'b0,  5'sd0,  11'h3FF},
        '{1'b0, 1'b0,  5'sd5,  11'h555},
        '{1'b0, 1'b0,  5'sd10, 11'h200},
        '{1'b0, 1'b0, -5'sd4,  11'h001},
        '{1'b0, 1'b0,  5'sd11, 11'h2AA},
        '{1'b1, 1'b0,  5'sd0,  11'h000},
        '{1'b0, 1'b0,  5'sd3,  11'h123},
        '{1'b0, 1'b1,  5'sd7,  11'h0F0},
        '{1'b0, 1'b0,  5'sd11, 11'h400},
        '{1'b0, 1'b0, -5'sd2,  11'h3FE},
        '{1'b1, 1'b0,  5'sd0,  11'h000},
        '{1'b1, 1'b0,  5'sd0,  11'h000},
        '{1'b0, 1'b0,  5'sd1,  11'h0AB},
        '{1'b0, 1'b1,  5'sd11, 11'h321},
        '{1'b0, 1'b0,  5'sd9,  11'h010},
        '{1'b0, 1'b0, -5'sd4,  11'h7FF},
        '{1'b0, 1'b0,  5'sd11, 11'h000},
        '{1'b0, 1'b0,  5'sd2,  11'h1C7},
        '{1'b0, 1'b0,  5'sd6,  11'h38E},
        '{1'b0, 1'b1, -5'sd3,  11'h05A},
        '{1'b0, 1'b0,  5'sd4,  11'h2D2},
        '{1'b0, 1'b0,  5'sd8,  11'h111},
        '{1'b0, 1'b0,  5'sd11, 11'h3C3}
    };

    logic                  clk  = 1'b0;
    logic                  rst  = 1'b1;
    logic                  dis  = 1'b0;
    logic [NS-1:0]         xfer = '0;
    logic [NS-1:0][10:0]   res  = '0;
    tri1  [9:0]            code_w;
    tri1                   ovr_w;
    wire                   vld_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    slice_interleave_mux i_slice_interleave_mux (
        .clk        (clk),
        .rst        (rst),
        .out_dis_i  (dis),
        .xfer_i     (xfer),
        .res_i      (res),
        .out_code_o (code_w),
        .out_ovr_o  (ovr_w),
        .out_vld_o  (vld_w)
    );

    function automatic vec_t get_vec(input int n);
        vec_t v;
        if (n < NTAB) begin
            v = VEC[n];
        end else begin
            v.skip  = 1'b0;
            v.decoy = 1'b0;
            v.off   = 5'((n % NS) - 4);
            v.res   = {((n % 5) == 0), 10'((n * 37 + 5) % 1024)};
        end
        return v;
    endfunction

    function automatic logic [10:0] sat(input logic [10:0] r);
        return r[10] ? 11'h7FF : r;
    endfunction

    task automatic check(input string tag, input logic [9:0] ec, input logic eo, input logic ev);
        checks++;
        if (code_w !== ec || ovr_w !== eo || vld_w !== ev) begin
            fails++;
            $display("FAIL %s: got code=%h ovr=%b vld=%b, expected code=%h ovr=%b vld=%b",
                     tag, code_w, ovr_w, vld_w, ec, eo, ev);
        end
    endtask

    initial begin
        logic [9:0]  last_c;
        logic        last_o;
        logic        prev_dis;
        logic [9:0]  ec;
        logic        eo;
        logic        ev;
        string       tag;
        vec_t        v;
        logic [10:0] w;

        last_c   = '0;
        last_o   = 1'b0;
        prev_dis = 1'b0;
        repeat (2) @(negedge clk);

        // Table walk: three rotations of the slices, then a quiet tail
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            if (c == 0) rst = 1'b0;
            dis = (c >= 14) && ((c % 9) >= 6);
            #1;
            if (c - LAT < 0) begin
                ec = '0; eo = 1'b0; ev = 1'b0;
                tag = (c == 0) ? "R1" : "R3";
            end else begin
                v = get_vec(c - LAT);
                if ((c - LAT) < NSMP && !v.skip) begin
                    w  = sat(v.res);
                    ec = w[9:0]; eo = w[10]; ev = 1'b1;
                    last_c = ec; last_o = eo;
                    if (v.res[10])                                   tag = "R7";
                    else if (v.decoy)                                tag = "R5";
                    else if (v.res[9:0] == '0 || v.res[9:0] == '1)   tag = "R8";
                    else if (v.off == 5'sd11 || v.off == -5'sd4)     tag = "R4";
                    else                                             tag = "R2";
                end else begin
                    ec = last_c; eo = last_o; ev = 1'b0;
                    tag = "R6";
                end
            end
            if (dis) begin
                ec = '1; eo = 1'b1;
                tag = "R9";
            end else if (prev_dis) begin
                tag = "R10";
            end
            check(tag, ec, eo, ev);
            prev_dis = dis;

            xfer = '0;
            res  = '0;
            for (int n = 0; n < NSMP; n++) begin
                v = get_vec(n);
                if (!v.skip) begin
                    if (c == n + int'(v.off)) begin
                        xfer[n % NS] = 1'b1;
                        res[n % NS]  = v.res;
                    end
                    if (v.decoy && c == n - 4) begin
                        xfer[n % NS] = 1'b1;
                        res[n % NS]  = ~v.res;
                    end
                end
            end
        end

        // Directed: reset again with every slice strobing every cycle
        @(negedge clk);
        rst  = 1'b1;
        dis  = 1'b0;
        xfer = '0;
        repeat (2) @(negedge clk);
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (c == 0) rst = 1'b0;
            #1;
            if (c == 0)       check("R1", 10'h000, 1'b0, 1'b0);
            else if (c < LAT) check("R3", 10'h000, 1'b0, 1'b0);
            else              check("R2", 10'(100 + c - LAT), 1'b0, 1'b1);
            xfer = '1;
            for (int k = 0; k < NS; k++) res[k] = 11'(100 + k);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule